// File: doc/BRIEF.md
# Synchronous Serial Transmitter with External Shift Clock

This block sends words over a synchronous serial link in which the far end supplies the shift clock. The block never drives the clock. It samples the incoming shift clock into the system clock domain and moves its data line forward by one bit on each falling edge it detects. Because the clock comes from outside, the transmitter keeps shifting while the surrounding core sleeps. Whenever its holding stage becomes free, the block raises a wake request.

The host writes words into a single holding stage that feeds a shift stage. If the shift stage is idle, a word goes straight into it. A word written while another is shifting waits in the holding stage. The moment the shift stage drains, the waiting word moves into it. An optional ninth bit extends each frame. Two status outputs report the state of the buffers: one for the holding stage and one for the shift stage. A set of mode inputs controls whether the transmitter runs at all. When the transmitter is not allowed to run, it stays idle and discards its contents.

Top module: `sync_slave_tx`

## Requirements
- R1: After reset, sr_empty_o is 1, hold_empty_o is 0, wake_o is 0 and sdo_o is 1.
- R2: The transmitter runs only while port_en_i, sync_mode_i and tx_en_i are 1 and clk_master_i and rx_en_i are 0. A write in any other case is dropped. Enabling the transmitter afterwards shows no stored word (sr_empty_o=1 and hold_empty_o=1).
- R3: A write while the transmitter runs and both stages are empty loads the shift stage directly. sr_empty_o falls in the next cycle and sdo_o shows data bit 0. hold_empty_o stays 1.
- R4: Bits leave least significant first. Each falling edge of sclk_i, after the two-flop synchronizer, advances sdo_o by one bit. With no word loaded, sclk_i edges have no effect and sdo_o idles at 1.
- R5: When nine_bit_i is 1 at load time, the frame is 9 bits long. The last bit is the value ninth_i had when the word was written. A later change to ninth_i does not affect the word.
- R6: A word written while the shift stage is busy stays in the holding stage. hold_empty_o and wake_o stay 0 until the shift stage finishes.
- R7: When the shift stage finishes, the held word moves into it within two cycles. hold_empty_o then rises and the held word is shifted out.
- R8: sr_empty_o stays 0 until the falling edge that ends the last bit (the 8th, or the 9th when enabled). It rises within four system cycles after that edge.
- R9: wake_o is 1 exactly when hold_empty_o is 1 and hold_ie_i is 1.
- R10: If the run condition of R2 drops, the transmitter discards the word being shifted and any held word. sr_empty_o becomes 1 and sdo_o returns to 1.
- R11: hold_empty_o is 0 while the run condition is false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Serial port enable |
| sync_mode_i | input | 1 | Synchronous mode select |
| clk_master_i | input | 1 | Clock source select; must be 0 (clock from outside) |
| tx_en_i | input | 1 | Transmit enable |
| rx_en_i | input | 1 | Any receive enable; must be 0 for transmit |
| nine_bit_i | input | 1 | Select 9-bit frames |
| ninth_i | input | 1 | Ninth data bit, captured at write |
| hold_ie_i | input | 1 | Wake request enable for empty holding stage |
| wr_i | input | 1 | Host write strobe |
| wdata_i | input | 8 | Host write data |
| sclk_i | input | 1 | External shift clock, asynchronous |
| sdo_o | output | 1 | Serial data out |
| hold_empty_o | output | 1 | Holding stage empty flag |
| sr_empty_o | output | 1 | Shift stage empty status |
| wake_o | output | 1 | Wake / interrupt request |

## Verification
The bench uses the default parameters: 8-bit words and a two-stage synchronizer. With these values, a full frame of 8 or 9 bits can be read off bit by bit in a short run. The bench holds the external clock at each level for eight system cycles. That interval covers the synchronizer latency, so the bench can check every bit of a frame as well as the exact bit at which the shift-empty status rises. It can also check the hand-over from the holding stage to the shift stage between two frames sent back to back.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  function automatic logic tx_active(input logic port_en, input logic sync_mode,
                                     input logic clk_master, input logic tx_en,
                                     input logic rx_en);
    return port_en & sync_mode & ~clk_master & tx_en & ~rx_en;
  endfunction
endpackage

// File: rtl/ssx_clk_sync.sv
module ssx_clk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sclk_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/ssx_hold.sv
module ssx_hold #(
  parameter int W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       wr_i,
  input  logic       bypass_i,
  input  logic       take_i,
  input  logic [W:0] din_i,
  output logic       full_o,
  output logic [W:0] dout_o
);
  logic capture;
  assign capture = active_i & wr_i & ~bypass_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      dout_o <= '0;
    end else begin
      full_o <= active_i & (capture | (full_o & ~take_i));
      if (capture) dout_o <= din_i;
    end
  end
endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter #(
  parameter int W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       load_i,
  input  logic       nine_i,
  input  logic [W:0] frame_i,
  input  logic       step_i,
  output logic       empty_o,
  output logic       sdo_o
);
  localparam int CW = $clog2(W + 2);

  logic [W:0]    sr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      empty_o <= 1'b1;
    end else if (!active_i) begin
      cnt_q   <= '0;
      empty_o <= 1'b1;
    end else if (load_i) begin
      sr_q    <= frame_i;
      cnt_q   <= nine_i ? CW'(W + 1) : CW'(W);
      empty_o <= 1'b0;
    end else if (step_i && !empty_o) begin
      sr_q  <= sr_q >> 1;
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) empty_o <= 1'b1;
    end
  end

  assign sdo_o = empty_o ? 1'b1 : sr_q[0];
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_en_i,
  input  logic              sync_mode_i,
  input  logic              clk_master_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              nine_bit_i,
  input  logic              ninth_i,
  input  logic              hold_ie_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sclk_i,
  output logic              sdo_o,
  output logic              hold_empty_o,
  output logic              sr_empty_o,
  output logic              wake_o
);
  import ssx_pkg::*;

  logic            active, fall, hold_full, bypass, take;
  logic [DATA_W:0] hold_q, frame;

  assign active = tx_active(port_en_i, sync_mode_i, clk_master_i, tx_en_i, rx_en_i);
  assign bypass = active & sr_empty_o & ~hold_full & wr_i;
  assign take   = active & sr_empty_o & hold_full;
  assign frame  = take ? hold_q : {ninth_i, wdata_i};

  ssx_clk_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sclk_i(sclk_i),
    .fall_o(fall)
  );

  ssx_hold #(.W(DATA_W)) i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .wr_i    (wr_i),
    .bypass_i(bypass),
    .take_i  (take),
    .din_i   ({ninth_i, wdata_i}),
    .full_o  (hold_full),
    .dout_o  (hold_q)
  );

  ssx_shifter #(.W(DATA_W)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .load_i  (bypass | take),
    .nine_i  (nine_bit_i),
    .frame_i (frame),
    .step_i  (fall),
    .empty_o (sr_empty_o),
    .sdo_o   (sdo_o)
  );

  assign hold_empty_o = active & ~hold_full;
  assign wake_o       = hold_empty_o & hold_ie_i;
endmodule

// File: rtl/sync_slave_tx_chk.sv
module sync_slave_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic port_en_i,
  input logic sync_mode_i,
  input logic clk_master_i,
  input logic tx_en_i,
  input logic rx_en_i,
  input logic wr_i,
  input logic sdo_o,
  input logic hold_empty_o,
  input logic sr_empty_o
);
  logic run;
  assign run = ssx_pkg::tx_active(port_en_i, sync_mode_i, clk_master_i, tx_en_i, rx_en_i);

  AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && sr_empty_o) |=> sr_empty_o);  // R2
  AST_DIRECT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && sr_empty_o && hold_empty_o && wr_i) |=> !sr_empty_o);  // R3
  AST_HOLD_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !hold_empty_o && !sr_empty_o) |=> (!hold_empty_o || !run));  // R6
  AST_HANDOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !hold_empty_o && sr_empty_o) |=> !sr_empty_o);  // R7
  AST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (sr_empty_o && sdo_o));  // R10
endmodule

bind sync_slave_tx sync_slave_tx_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .port_en_i   (port_en_i),
  .sync_mode_i (sync_mode_i),
  .clk_master_i(clk_master_i),
  .tx_en_i     (tx_en_i),
  .rx_en_i     (rx_en_i),
  .wr_i        (wr_i),
  .sdo_o       (sdo_o),
  .hold_empty_o(hold_empty_o),
  .sr_empty_o  (sr_empty_o)
);

// File: tb/test_sync_slave_tx.sv
module test_sync_slave_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic port_en = 0, sync_mode = 0, clk_master = 0, tx_en = 0, rx_en = 0;
  logic nine_bit = 0, ninth = 0, hold_ie = 0, wr = 0, sclk = 1'b1;
  logic [7:0] wdata = '0;
  logic sdo, hold_empty, sr_empty, wake;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sync_slave_tx i_sync_slave_tx (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .sync_mode_i(sync_mode),
    .clk_master_i(clk_master), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .nine_bit_i(nine_bit), .ninth_i(ninth), .hold_ie_i(hold_ie), .wr_i(wr),
    .wdata_i(wdata), .sclk_i(sclk), .sdo_o(sdo), .hold_empty_o(hold_empty),
    .sr_empty_o(sr_empty), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic enable_all();
    port_en = 1; sync_mode = 1; clk_master = 0; tx_en = 1; rx_en = 0;
    @(negedge clk);
  endtask

  task automatic write_word(input logic [7:0] d);
    wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
    @(negedge clk);
  endtask

  task automatic shift_bits(input int n, output logic [8:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      got[i] = sdo;
      sclk = 0;
      repeat (8) @(negedge clk);
      sclk = 1;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 sr_empty", sr_empty, 1);
    chk("R1 hold_empty", hold_empty, 0);
    chk("R1 wake", wake, 0);
    chk("R1 sdo", sdo, 1);
  endtask

  task automatic t_idle_clock();
    logic [8:0] g;
    enable_all();
    chk("R11 flag when enabled", hold_empty, 1);
    shift_bits(3, g);
    chk("R4 idle clock sdo", g, 9'h007);
    chk("R4 idle clock sr_empty", sr_empty, 1);
  endtask

  task automatic t_single();
    logic [8:0] g;
    write_word(8'hA5);
    chk("R3 sr_empty low", sr_empty, 0);
    chk("R3 hold stays empty", hold_empty, 1);
    chk("R3 first bit", sdo, 1);
    shift_bits(8, g);
    chk("R4 lsb first", g[7:0], 8'hA5);
    chk("R8 sr_empty after frame", sr_empty, 1);
    write_word(8'h3C);
    shift_bits(7, g);
    chk("R8 busy before last bit", sr_empty, 0);
    shift_bits(1, g);
    chk("R8 empty after last bit", sr_empty, 1);
  endtask

  task automatic t_nine();
    logic [8:0] g;
    nine_bit = 1; ninth = 1;
    @(negedge clk);
    write_word(8'h0F);
    shift_bits(9, g);
    chk("R5 ninth one", g, 9'h10F);
    ninth = 0;
    @(negedge clk);
    write_word(8'hF0);
    ninth = 1;
    shift_bits(9, g);
    chk("R5 ninth captured at write", g, 9'h0F0);
    nine_bit = 0; ninth = 0;
    @(negedge clk);
  endtask

  task automatic t_double();
    logic [8:0] g;
    hold_ie = 1;
    @(negedge clk);
    chk("R9 wake when empty", wake, 1);
    wdata = 8'h11; wr = 1;
    @(negedge clk);
    wdata = 8'h96;
    @(negedge clk);
    wr = 0;
    @(negedge clk);
    chk("R6 hold full", hold_empty, 0);
    chk("R9 no wake while held", wake, 0);
    shift_bits(8, g);
    chk("R6 first word", g[7:0], 8'h11);
    chk("R7 hold empty after handover", hold_empty, 1);
    chk("R9 wake after handover", wake, 1);
    chk("R7 second word loaded", sr_empty, 0);
    shift_bits(8, g);
    chk("R7 second word", g[7:0], 8'h96);
    hold_ie = 0;
    @(negedge clk);
    chk("R9 wake masked", wake, 0);
  endtask

  task automatic t_inactive();
    tx_en = 0;
    @(negedge clk);
    write_word(8'h55);
    chk("R2 tx_en off ignored", sr_empty, 1);
    chk("R11 flag off", hold_empty, 0);
    tx_en = 1;
    @(negedge clk);
    chk("R2 nothing stored", sr_empty, 1);
    chk("R2 hold empty", hold_empty, 1);
    clk_master = 1;
    @(negedge clk);
    write_word(8'h55);
    clk_master = 0;
    @(negedge clk);
    chk("R2 master mode ignored", sr_empty, 1);
    rx_en = 1;
    @(negedge clk);
    write_word(8'h55);
    rx_en = 0;
    @(negedge clk);
    chk("R2 receive on ignored", sr_empty, 1);
    chk("R2 hold after rx", hold_empty, 1);
  endtask

  task automatic t_abort();
    logic [8:0] g;
    wdata = 8'h80; wr = 1;
    @(negedge clk);
    wdata = 8'h42;
    @(negedge clk);
    wr = 0;
    shift_bits(3, g);
    chk("R10 pre-abort busy", sr_empty, 0);
    tx_en = 0;
    repeat (2) @(negedge clk);
    chk("R10 shift flushed", sr_empty, 1);
    chk("R10 line idle", sdo, 1);
    tx_en = 1;
    repeat (2) @(negedge clk);
    chk("R10 hold flushed", hold_empty, 1);
    chk("R10 nothing reloaded", sr_empty, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle_clock();
    t_single();
    t_nine();
    t_double();
    t_inactive();
    t_abort();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule